// File: doc/BRIEF.md
# Burst accounting monitor

This block sits beside one bus master and keeps the books for that master's current guaranteed burst. Software arms it with a reservation (a count of transactions plus gaps), a window length in clock cycles and an idle-gap threshold, then issues a start command. From the next cycle on, the block counts completed cache-line transactions, elapsed cycles, cycles with the bus unit busy, and the number of times the bus unit went from idle back to busy. It also keeps a combined count of transactions plus gaps.

The burst closes on the first of three events: the combined count reaches the reservation, the elapsed count reaches the window length, or the bus unit stays idle for the threshold number of consecutive cycles. On that edge the block pulses its interrupt for one cycle, sets the matching bits of a sticky cause register and returns every counter to zero. When the reservation register holds zero and no burst is open, the first completed transaction pulses the interrupt with a separate cause bit. Software uses this to learn that the master has begun a burst without an explicit start.

Every port is a plain control or status signal. There is no data stream and no flow control. A configuration write takes effect on the clock edge that samples it. The cause bits and counters are read directly from output ports.

Top module: `burst_acct_mon`

## Requirements
- R1: After reset, in_burst, irq, cause and every counter are zero, and the reservation, window and gap-threshold registers hold zero.
- R2: A write to address 3 with bit 0 set opens a burst when none is open: in_burst is 1 from the following cycle, and all counters start from zero. The same command during an open burst has no effect on the counters or on in_burst.
- R3: Each in-burst cycle with txn_done high adds one to txn_cnt and one to comb_cnt. Reads and writes count alike. Each in-burst cycle adds one to elapsed, and each in-burst cycle with bus_busy high adds one to busy_cyc.
- R4: An in-burst cycle with bus_busy high, where bus_busy was low in the previous cycle, adds one to gap_cnt and one to comb_cnt. This can happen in the same cycle as a transaction, in which case comb_cnt gains two.
- R5: When the reservation (address 0) is nonzero and comb_cnt, including this cycle's increments, reaches it, the burst closes on that edge and cause bit 0 is set.
- R6: When the window (address 1) is nonzero and elapsed, including this cycle, reaches it, the burst closes on that edge and cause bit 1 is set.
- R7: When the gap threshold (address 2) is nonzero and the run of consecutive idle in-burst cycles reaches it, the burst closes on that edge and cause bit 2 is set.
- R8: irq goes high for exactly one cycle, on the edge where the burst closes. If several closing conditions hold in the same cycle, all of their cause bits are set. Cause bits stay set until a write to address 3 with bit 1 set clears them; a bit that is raised on the same edge as the clear survives.
- R9: While no burst is open and the reservation register is zero, a txn_done pulse raises a one-cycle irq and sets cause bit 3, and no burst is opened. With a nonzero reservation, the same pulse does nothing.
- R10: While no burst is open, all counters read zero and transactions outside a burst are not counted. Every counter returns to zero on the edge that closes a burst.
- R11: Each counter stops at its all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | 0 reservation, 1 window, 2 gap threshold, 3 command |
| cfg_wdata | input | DATA_W | Write data; command bit 0 start, bit 1 clear cause |
| txn_done | input | 1 | One-cycle pulse per completed cache-line read or write |
| bus_busy | input | 1 | Bus unit busy level |
| irq | output | 1 | One-cycle interrupt pulse |
| in_burst | output | 1 | A guaranteed burst is open |
| cause | output | 4 | Sticky cause: bit0 reservation, bit1 window, bit2 gap, bit3 start detect |
| txn_cnt | output | CNT_W | Transactions in this burst |
| gap_cnt | output | CNT_W | Idle-to-busy transitions in this burst |
| comb_cnt | output | CNT_W | Transactions plus gaps |
| elapsed | output | TIME_W | Cycles since the burst opened |
| busy_cyc | output | TIME_W | Busy cycles since the burst opened |

## Verification
The bench builds the block with CNT_W=4, TIME_W=8 and GAP_W=4. With a 4-bit counter, twenty back-to-back transactions are enough to reach the saturation point, and small reservations, windows and thresholds let each closing condition occur within a few cycles. The table walks the reservation, window and gap closes, a case where two conditions coincide, and a case where a gap at the very start of a burst is counted. Directed steps cover start detection, starting a burst that is already open, and stopping at the counter limit.

// File: rtl/bam_pkg.sv
package bam_pkg;
  typedef enum logic [1:0] {
    SEL_RESV   = 2'd0,
    SEL_WINDOW = 2'd1,
    SEL_GAPTHR = 2'd2,
    SEL_CMD    = 2'd3
  } cfg_sel_e;

  localparam int CAUSE_W   = 4;
  localparam int CB_RESV   = 0;
  localparam int CB_WINDOW = 1;
  localparam int CB_GAP    = 2;
  localparam int CB_START  = 3;

  localparam int CMD_OPEN  = 0;
  localparam int CMD_CLEAR = 1;
endpackage

// File: rtl/bam_sat_ctr.sv
module bam_sat_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [1:0]   inc,
  output logic [W-1:0] q,
  output logic [W-1:0] nxt
);
  localparam logic [W:0] TOP = {1'b0, {W{1'b1}}};

  logic [W:0] sum;

  always_comb begin
    sum = {1'b0, q} + {{(W-1){1'b0}}, inc};
    if (!en)           nxt = q;
    else if (sum > TOP) nxt = TOP[W-1:0];
    else                nxt = sum[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else          q <= nxt;
  end

  // R11: a full counter stays full until cleared
  assert_no_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (q == {W{1'b1}} && !clr) |=> (q == {W{1'b1}}));
endmodule

// File: rtl/bam_cfg_regs.sv
module bam_cfg_regs
  import bam_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int TIME_W = 16,
  parameter int GAP_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [CNT_W-1:0]  resv,
  output logic [TIME_W-1:0] window,
  output logic [GAP_W-1:0]  gap_thr,
  output logic              open_req,
  output logic              clear_req
);
  cfg_sel_e sel;
  logic     unused_wdata_bits;

  assign sel               = cfg_sel_e'(cfg_addr);
  assign open_req          = cfg_we && (sel == SEL_CMD) && cfg_wdata[CMD_OPEN];
  assign clear_req         = cfg_we && (sel == SEL_CMD) && cfg_wdata[CMD_CLEAR];
  assign unused_wdata_bits = ^cfg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resv    <= '0;
      window  <= '0;
      gap_thr <= '0;
    end else if (cfg_we) begin
      case (sel)
        SEL_RESV:   resv    <= cfg_wdata[CNT_W-1:0];
        SEL_WINDOW: window  <= cfg_wdata[TIME_W-1:0];
        SEL_GAPTHR: gap_thr <= cfg_wdata[GAP_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bam_idle_watch.sv
module bam_idle_watch #(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             busy,
  input  logic             clr,
  input  logic [GAP_W-1:0] thr,
  output logic             hit
);
  logic [GAP_W-1:0] run_q;
  logic [GAP_W-1:0] run_nxt;

  bam_sat_ctr #(.W(GAP_W)) u_run (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr || busy),
    .en   (en && !busy),
    .inc  (2'd1),
    .q    (run_q),
    .nxt  (run_nxt)
  );

  assign hit = en && !busy && (thr != '0) && (run_nxt >= thr);

  // R7: an idle run never sits at or above a steady threshold
  assert_idle_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && thr != '0 && $stable(thr)) |-> (run_q < thr));
endmodule

// File: rtl/burst_acct_mon.sv
module burst_acct_mon
  import bam_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int TIME_W = 16,
  parameter int GAP_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              txn_done,
  input  logic              bus_busy,
  output logic              irq,
  output logic              in_burst,
  output logic [CAUSE_W-1:0] cause,
  output logic [CNT_W-1:0]  txn_cnt,
  output logic [CNT_W-1:0]  gap_cnt,
  output logic [CNT_W-1:0]  comb_cnt,
  output logic [TIME_W-1:0] elapsed,
  output logic [TIME_W-1:0] busy_cyc
);
  localparam int NEV = 3;

  logic [CNT_W-1:0]  resv;
  logic [TIME_W-1:0] window;
  logic [GAP_W-1:0]  gap_thr;
  logic              open_req, clear_req;

  bam_cfg_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .TIME_W(TIME_W), .GAP_W(GAP_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .resv     (resv),
    .window   (window),
    .gap_thr  (gap_thr),
    .open_req (open_req),
    .clear_req(clear_req)
  );

  logic busy_q, open_q, irq_q;
  logic [CAUSE_W-1:0] cause_q;
  logic txn_hit, rise, ctr_clr, end_any;
  logic resv_hit, win_hit, gap_hit, start_det;

  assign txn_hit = open_q && txn_done;
  assign rise    = open_q && bus_busy && !busy_q;

  // event counters: 0 transactions, 1 gaps, 2 combined
  logic [1:0]       ev_inc [NEV];
  logic [CNT_W-1:0] ev_q   [NEV];
  logic [CNT_W-1:0] ev_nxt [NEV];

  assign ev_inc[0] = {1'b0, txn_hit};
  assign ev_inc[1] = {1'b0, rise};
  assign ev_inc[2] = {1'b0, txn_hit} + {1'b0, rise};

  generate
    for (genvar g = 0; g < NEV; g++) begin : g_ev
      bam_sat_ctr #(.W(CNT_W)) u_ctr (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (ctr_clr),
        .en   (open_q),
        .inc  (ev_inc[g]),
        .q    (ev_q[g]),
        .nxt  (ev_nxt[g])
      );
    end
  endgenerate

  logic [TIME_W-1:0] el_nxt;
  logic [TIME_W-1:0] busy_nxt_unused;

  bam_sat_ctr #(.W(TIME_W)) u_elapsed (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (ctr_clr),
    .en   (open_q),
    .inc  (2'd1),
    .q    (elapsed),
    .nxt  (el_nxt)
  );

  bam_sat_ctr #(.W(TIME_W)) u_busy (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (ctr_clr),
    .en   (open_q),
    .inc  ({1'b0, bus_busy}),
    .q    (busy_cyc),
    .nxt  (busy_nxt_unused)
  );

  bam_idle_watch #(.GAP_W(GAP_W)) u_idle (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (open_q),
    .busy (bus_busy),
    .clr  (ctr_clr),
    .thr  (gap_thr),
    .hit  (gap_hit)
  );

  assign resv_hit  = open_q && (resv != '0) && (ev_nxt[2] >= resv);
  assign win_hit   = open_q && (window != '0) && (el_nxt >= window);
  assign end_any   = resv_hit || win_hit || gap_hit;
  assign ctr_clr   = !open_q || end_any;
  assign start_det = !open_q && (resv == '0) && txn_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      open_q  <= 1'b0;
      irq_q   <= 1'b0;
      cause_q <= '0;
    end else begin
      busy_q <= bus_busy;
      if (end_any)       open_q <= 1'b0;
      else if (open_req) open_q <= 1'b1;
      irq_q   <= end_any || start_det;
      cause_q <= (clear_req ? '0 : cause_q) | {start_det, gap_hit, win_hit, resv_hit};
    end
  end

  assign irq      = irq_q;
  assign in_burst = open_q;
  assign cause    = cause_q;
  assign txn_cnt  = ev_q[0];
  assign gap_cnt  = ev_q[1];
  assign comb_cnt = ev_q[2];

  // R8: closing a burst always pulses irq with a closing cause
  assert_close_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(open_q) |-> (irq_q && (cause_q[2:0] != '0)));

  // R8: cause bits only drop after a clear command
  assert_cause_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_req |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

  // R10: counters are zero whenever no burst is open
  assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !open_q |-> (txn_cnt == '0 && gap_cnt == '0 && comb_cnt == '0 &&
                 elapsed == '0 && busy_cyc == '0));

  // R6: elapsed stays under a steady window
  assert_window_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && window != '0 && $stable(window)) |-> (elapsed < window));

  // R9: start detection flags without opening a burst
  assert_start_detect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_q && resv == '0 && txn_done && !open_req) |=> (irq_q && cause_q[CB_START] && !open_q));
endmodule

// File: tb/sim_burst_acct_mon.sv
`timescale 1ns/1ps
module sim_burst_acct_mon;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 4;
  localparam int TIME_W = 8;
  localparam int GAP_W  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [DATA_W-1:0] cfg_wdata = '0;
  logic txn_done = 1'b0;
  logic bus_busy = 1'b0;
  logic irq, in_burst;
  logic [3:0] cause;
  logic [CNT_W-1:0] txn_cnt, gap_cnt, comb_cnt;
  logic [TIME_W-1:0] elapsed, busy_cyc;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  burst_acct_mon #(.DATA_W(DATA_W), .CNT_W(CNT_W), .TIME_W(TIME_W), .GAP_W(GAP_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .txn_done(txn_done), .bus_busy(bus_busy), .irq(irq), .in_burst(in_burst), .cause(cause),
    .txn_cnt(txn_cnt), .gap_cnt(gap_cnt), .comb_cnt(comb_cnt), .elapsed(elapsed), .busy_cyc(busy_cyc)
  );

  // vectors: reservation, window, threshold, pulses, busy length, busy before start,
  // expected cause, expected closing index
  localparam int NV = 6;
  localparam int V_RESV [NV] = '{3, 0, 0, 4, 3, 0};
  localparam int V_WIN  [NV] = '{0, 5, 0, 4, 0, 3};
  localparam int V_THR  [NV] = '{0, 0, 3, 0, 0, 2};
  localparam int V_NTX  [NV] = '{10, 2, 2, 10, 2, 0};
  localparam int V_BLEN [NV] = '{255, 255, 4, 255, 255, 1};
  localparam int V_PRE  [NV] = '{1, 1, 1, 1, 0, 1};
  localparam int V_CAUSE[NV] = '{1, 2, 4, 3, 1, 6};
  localparam int V_END  [NV] = '{2, 4, 6, 3, 1, 2};

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = addr[1:0]; cfg_wdata = data[DATA_W-1:0];
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset", !irq && !in_burst && cause == 0 && txn_cnt == 0 && gap_cnt == 0 &&
        comb_cnt == 0 && elapsed == 0 && busy_cyc == 0, int'(cause), 0);

    // R9 start detection with zero reservation
    txn_done = 1'b1;
    @(negedge clk);
    txn_done = 1'b0;
    chk("R9 start detect irq", irq && !in_burst, int'(irq), 1);
    chk("R9 start detect cause", cause == 4'b1000, int'(cause), 8);
    @(negedge clk);
    chk("R8 irq single cycle", !irq, int'(irq), 0);
    wr(3, 2);
    wr(0, 5);
    txn_done = 1'b1;
    @(negedge clk);
    txn_done = 1'b0;
    chk("R9 no detect with reservation", !irq && cause == 0, int'(cause), 0);
    chk("R10 no count outside burst", txn_cnt == 0 && !in_burst, int'(txn_cnt), 0);

    // table of closing scenarios
    for (int v = 0; v < NV; v++) begin
      int end_i, seen_cause, pulses;
      end_i = -1; seen_cause = 0; pulses = 0;
      wr(3, 2);
      wr(0, V_RESV[v]);
      wr(1, V_WIN[v]);
      wr(2, V_THR[v]);
      bus_busy = (V_PRE[v] != 0);
      wr(3, 1);
      for (int i = 0; i < 10; i++) begin
        txn_done = (i < V_NTX[v]);
        bus_busy = (i < V_BLEN[v]);
        @(negedge clk);
        if (irq) begin
          pulses++;
          if (end_i < 0) begin end_i = i; seen_cause = int'(cause); end
        end
      end
      txn_done = 1'b0; bus_busy = 1'b1;
      // R5 R6 R7 closing point and cause, R8 single pulse
      chk($sformatf("R5/R6/R7 vector %0d close index", v), end_i == V_END[v], end_i, V_END[v]);
      chk($sformatf("R8 vector %0d cause", v), seen_cause == V_CAUSE[v], seen_cause, V_CAUSE[v]);
      chk($sformatf("R8 vector %0d pulse count", v), pulses == 1, pulses, 1);
      chk($sformatf("R10 vector %0d cleared", v), !in_burst && txn_cnt == 0 && comb_cnt == 0,
          int'(comb_cnt), 0);
    end
    chk("R8 cause sticky", cause == 4'd6, int'(cause), 6);
    wr(3, 2);
    chk("R8 cause clear", cause == 0, int'(cause), 0);

    // directed: counting of transactions, gaps, busy cycles
    wr(0, 0); wr(1, 0); wr(2, 0);
    bus_busy = 1'b1;
    wr(3, 1);
    chk("R2 open", in_burst && txn_cnt == 0 && elapsed == 0, int'(in_burst), 1);
    for (int i = 0; i < 5; i++) begin
      bus_busy = (i % 2 == 0);
      txn_done = (i != 2 && i != 4);
      @(negedge clk);
    end
    txn_done = 1'b0; bus_busy = 1'b1;
    chk("R3 txn count", txn_cnt == 3, int'(txn_cnt), 3);
    chk("R4 gap count", gap_cnt == 2, int'(gap_cnt), 2);
    chk("R4 combined count", comb_cnt == 5, int'(comb_cnt), 5);
    chk("R3 elapsed", elapsed == 5, int'(elapsed), 5);
    chk("R3 busy cycles", busy_cyc == 3, int'(busy_cyc), 3);
    wr(3, 1);
    chk("R2 open ignored in burst", in_burst && txn_cnt == 3 && comb_cnt == 5, int'(txn_cnt), 3);
    wr(1, 1);
    @(negedge clk);
    chk("R6 late window close", !in_burst && cause == 4'd2, int'(cause), 2);
    chk("R10 counters cleared", txn_cnt == 0 && gap_cnt == 0 && elapsed == 0, int'(elapsed), 0);
    wr(1, 0);
    wr(3, 2);

    // directed: saturation
    wr(3, 1);
    for (int i = 0; i < 20; i++) begin
      txn_done = 1'b1;
      @(negedge clk);
    end
    txn_done = 1'b0;
    chk("R11 txn saturates", txn_cnt == 15, int'(txn_cnt), 15);
    chk("R11 combined saturates", comb_cnt == 15, int'(comb_cnt), 15);
    chk("R3 elapsed after run", elapsed == 20, int'(elapsed), 20);
    wr(1, 1);
    @(negedge clk);
    chk("R6 close after saturation", !in_burst && txn_cnt == 0, int'(in_burst), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule